// File: doc/BRIEF.md
# Instruction Dispatch Group Former

This block sits between decode and dispatch. It takes decoded instructions one per cycle on a valid/ready stream. Each instruction carries a class code and a tag. The block packs them, in program order, into dispatch groups of six slots. Slots 1 to 4 hold non-branch work and slots 5 and 6 hold branches. Each class has its own slot rules. While one instruction after another fits, the group keeps growing. The group is handed downstream, with a group-valid strobe, per-slot valid bits and the tag held in each slot, when one of these happens: the next instruction cannot be placed, a second branch has been placed, or the input runs dry.

The output is a single register stage. When downstream stalls, that register holds its value. The input is then stalled only if the instruction on offer would need a group to be emitted.

Top module: `dispatch_group_former`

## Requirements
- R1: After reset, `grp_valid` is 0 and `in_ready` is 1.
- R2: Class 0 (plain work; codes 6 and 7 are treated the same way) takes the lowest-numbered free slot among 1 to 4. When slots 1 to 4 are all used, the next class-0 instruction closes the current group and starts a new one.
- R3: Class 3 (branch) takes slot 5, or slot 6 if slot 5 is already used. A single branch leaves the group open, so later non-branch instructions join the same group.
- R4: A branch placed into slot 6 closes the group. The emitted group includes that branch.
- R5: Class 1 (cracked) occupies slots 1 and 2 together, with its tag in both. It is placed only into an empty group; otherwise the current group closes first.
- R6: Class 2 (serialising) occupies slots 1 to 4, with its tag in all four. It is placed only into an empty group. A branch that follows it may still join its group.
- R7: Class 4 (write to condition register) may use only slot 4, and class 5 (read from condition register) may use only slot 1. When that slot is taken, the current group closes first.
- R8: When no valid instruction is offered and the open group is non-empty, the group is emitted on the next clock edge.
- R9: While `grp_valid` is 1 and `grp_ready` is 0, the outputs do not change. Every accepted instruction appears in exactly one emitted group, and groups come out in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction is taken on this edge |
| in_class | input | 3 | Class code (0 plain, 1 cracked, 2 serialising, 3 branch, 4 to-CR, 5 from-CR) |
| in_tag | input | TAG_W | Instruction identifier |
| grp_valid | output | 1 | An emitted group is present |
| grp_ready | input | 1 | Downstream takes the group |
| slot_valid | output | 6 | Bit k set when slot k+1 is used |
| slot_tag | output | 6*TAG_W | Tag of slot k+1 at bits [k*TAG_W +: TAG_W]; zero for unused slots |

## Verification
The main tests are short instruction sequences, each built to separate one closing cause from the others: a fifth plain instruction (non-branch part full), a branch then plain work (group must stay open), two branches (closing on slot 6), and a cracked, serialising or condition-register instruction arriving behind other work (closing on slot conflict). A branch ahead of a serialising instruction checks that the empty-group rule counts branch slots too. A mixed run with random downstream stalls checks that holding the output never drops, repeats or reorders a group. An isolated instruction followed by idle cycles measures the flush latency.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int NB_SLOTS = 4;
  localparam int BR_SLOTS = 2;
  localparam int SLOTS    = NB_SLOTS + BR_SLOTS;

  typedef enum logic [2:0] {
    CL_PLAIN   = 3'd0,
    CL_PAIR    = 3'd1,
    CL_FULL    = 3'd2,
    CL_BRANCH  = 3'd3,
    CL_TO_CR   = 3'd4,
    CL_FROM_CR = 3'd5
  } iclass_e;

  // Slots an instruction of class cls would take given the occupancy occ;
  // zero when it cannot be placed.
  function automatic logic [SLOTS-1:0] pick_slots(logic [SLOTS-1:0] occ, logic [2:0] cls);
    logic [SLOTS-1:0] m;
    m = '0;
    case (cls)
      CL_PAIR:    if (occ == '0) m = SLOTS'(3);
      CL_FULL:    if (occ == '0) m = SLOTS'((1 << NB_SLOTS) - 1);
      CL_BRANCH: begin
        if (!occ[NB_SLOTS])          m = SLOTS'(1) << NB_SLOTS;
        else if (!occ[NB_SLOTS + 1]) m = SLOTS'(1) << (NB_SLOTS + 1);
      end
      CL_TO_CR:   if (!occ[NB_SLOTS-1]) m = SLOTS'(1) << (NB_SLOTS - 1);
      CL_FROM_CR: if (!occ[0]) m = SLOTS'(1);
      default: begin
        for (int i = NB_SLOTS - 1; i >= 0; i--)
          if (!occ[i]) m = SLOTS'(1) << i;
      end
    endcase
    return m;
  endfunction

  // True when placing cls seals the group (second branch).
  function automatic logic seals_group(logic [SLOTS-1:0] occ, logic [2:0] cls);
    return (cls == CL_BRANCH) && occ[NB_SLOTS];
  endfunction
endpackage

// File: rtl/dgf_place.sv
module dgf_place
  import dgf_pkg::*;
(
  input  logic [SLOTS-1:0] occ,
  input  logic [2:0]       cls,
  output logic [SLOTS-1:0] place,
  output logic             fits,
  output logic             seals
);
  always_comb begin
    place = pick_slots(occ, cls);
    fits  = (place != '0);
    seals = fits && seals_group(occ, cls);
  end
endmodule

// File: rtl/dgf_outreg.sv
module dgf_outreg
  import dgf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [SLOTS-1:0]       ld_valid,
  input  logic [SLOTS*TAG_W-1:0] ld_tag,
  input  logic                   ready,
  output logic                   grp_valid,
  output logic [SLOTS-1:0]       slot_valid,
  output logic [SLOTS*TAG_W-1:0] slot_tag,
  output logic                   free
);
  assign free = !grp_valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_valid  <= 1'b0;
      slot_valid <= '0;
      slot_tag   <= '0;
    end else if (load) begin
      grp_valid  <= 1'b1;
      slot_valid <= ld_valid;
      slot_tag   <= ld_tag;
    end else if (ready) begin
      grp_valid  <= 1'b0;
      slot_valid <= '0;
      slot_tag   <= '0;
    end
  end
endmodule

// File: rtl/dispatch_group_former.sv
module dispatch_group_former
  import dgf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2:0]             in_class,
  input  logic [TAG_W-1:0]       in_tag,
  output logic                   grp_valid,
  input  logic                   grp_ready,
  output logic [SLOTS-1:0]       slot_valid,
  output logic [SLOTS*TAG_W-1:0] slot_tag
);
  localparam logic [SLOTS-1:0] NONE = '0;

  logic [SLOTS-1:0] acc_occ;
  logic [TAG_W-1:0] acc_tag [SLOTS];

  // named internal events
  logic [SLOTS-1:0] place_w, fresh_w, unused_fresh_w;
  logic             fits_w, seals_w, fresh_fits_w, fresh_seals_w;
  logic             out_free_w, take_w, spill_w, seal_w, idle_w, emit_w;
  logic [SLOTS-1:0]       emit_valid_w;
  logic [SLOTS*TAG_W-1:0] emit_tag_w;

  // placement into the open group
  dgf_place u_place_cur (
    .occ(acc_occ), .cls(in_class), .place(place_w), .fits(fits_w), .seals(seals_w));
  // placement into a freshly opened group
  dgf_place u_place_new (
    .occ(NONE), .cls(in_class), .place(fresh_w), .fits(fresh_fits_w), .seals(fresh_seals_w));

  assign unused_fresh_w = fresh_w & {SLOTS{fresh_fits_w & ~fresh_seals_w}};

  assign in_ready = out_free_w || (fits_w && !seals_w);
  assign take_w   = in_valid && in_ready;
  assign spill_w  = in_valid && !fits_w;
  assign seal_w   = in_valid && seals_w;
  assign idle_w   = !in_valid && (acc_occ != '0);
  assign emit_w   = out_free_w && (spill_w || seal_w || idle_w);

  assign emit_valid_w = seal_w ? (acc_occ | place_w) : acc_occ;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_comb begin
      if (!emit_valid_w[k])             emit_tag_w[k*TAG_W +: TAG_W] = '0;
      else if (seal_w && place_w[k])    emit_tag_w[k*TAG_W +: TAG_W] = in_tag;
      else                              emit_tag_w[k*TAG_W +: TAG_W] = acc_tag[k];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        acc_tag[k] <= '0;
      else if (take_w && (fits_w ? place_w[k] : unused_fresh_w[k]))
        acc_tag[k] <= in_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc_occ <= '0;
    else if (take_w) begin
      if (!fits_w)      acc_occ <= unused_fresh_w;
      else if (seals_w) acc_occ <= '0;
      else              acc_occ <= acc_occ | place_w;
    end else if (emit_w)
      acc_occ <= '0;
  end

  dgf_outreg #(.TAG_W(TAG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit_w), .ld_valid(emit_valid_w), .ld_tag(emit_tag_w),
    .ready(grp_ready), .grp_valid(grp_valid), .slot_valid(slot_valid), .slot_tag(slot_tag),
    .free(out_free_w));
endmodule

// File: rtl/dgf_checker.sv
module dgf_checker
  import dgf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   grp_valid,
  input logic                   grp_ready,
  input logic [SLOTS-1:0]       slot_valid,
  input logic [SLOTS*TAG_W-1:0] slot_tag,
  input logic                   take,
  input logic                   fits,
  input logic [SLOTS-1:0]       place,
  input logic [SLOTS-1:0]       fresh,
  input logic [SLOTS-1:0]       acc_occ,
  input logic [2:0]             in_class
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && !grp_ready |=> grp_valid && $stable(slot_valid) && $stable(slot_tag));

  assert_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> slot_valid != '0);

  assert_branch_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> !(slot_valid[NB_SLOTS+1] && !slot_valid[NB_SLOTS]));

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && fits |-> (place & acc_occ) == '0);

  assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_class == CL_PAIR |-> (fits ? place : fresh) == SLOTS'(3));

  assert_from_cr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_class == CL_FROM_CR |-> $countones(fits ? place : fresh) == 1
                                       && (fits ? place[0] : fresh[0]));
endmodule

bind dispatch_group_former dgf_checker #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
  .slot_valid(slot_valid), .slot_tag(slot_tag), .take(take_w), .fits(fits_w),
  .place(place_w), .fresh(fresh_w), .acc_occ(acc_occ), .in_class(in_class));

// File: tb/dispatch_group_former_bench.sv
module dispatch_group_former_bench;
  localparam int TW = 8;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_class = 3'd0;
  logic [TW-1:0] in_tag = '0;
  logic grp_valid;
  logic grp_ready = 1'b1;
  logic [NS-1:0] slot_valid;
  logic [NS*TW-1:0] slot_tag;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit bp_on = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;
  logic [TW-1:0] next_tag = 8'd1;

  logic [NS+NS*TW-1:0] exp_q [$];
  logic [NS-1:0] m_occ = '0;
  logic [NS*TW-1:0] m_tags = '0;

  always #4 clk = ~clk;

  dispatch_group_former #(.TAG_W(TW)) u_dispatch_group_former (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_tag(in_tag), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .slot_valid(slot_valid), .slot_tag(slot_tag));

  // downstream ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    grp_ready <= !bp_on || lfsr[0];
  end

  // reference slot choice, written from the requirements
  function automatic logic [NS-1:0] want_slots(logic [NS-1:0] occ, logic [2:0] cls);
    if (cls == 3'd1) return (occ == 0) ? 6'b000011 : 6'b0;           // R5
    if (cls == 3'd2) return (occ == 0) ? 6'b001111 : 6'b0;           // R6
    if (cls == 3'd3) begin                                           // R3
      if (occ[4] == 1'b0) return 6'b010000;
      if (occ[5] == 1'b0) return 6'b100000;
      return 6'b0;
    end
    if (cls == 3'd4) return occ[3] ? 6'b0 : 6'b001000;               // R7
    if (cls == 3'd5) return occ[0] ? 6'b0 : 6'b000001;               // R7
    if (!occ[0]) return 6'b000001;                                   // R2
    if (!occ[1]) return 6'b000010;
    if (!occ[2]) return 6'b000100;
    if (!occ[3]) return 6'b001000;
    return 6'b0;
  endfunction

  task automatic m_close();
    if (m_occ != 0) exp_q.push_back({m_occ, m_tags});
    m_occ = '0;
    m_tags = '0;
  endtask

  task automatic m_add(input logic [2:0] cls, input logic [TW-1:0] tag);
    logic [NS-1:0] mk;
    mk = want_slots(m_occ, cls);
    if (mk == 0) begin
      m_close();
      mk = want_slots(m_occ, cls);
    end
    for (int k = 0; k < NS; k++) if (mk[k]) m_tags[k*TW +: TW] = tag;
    m_occ = m_occ | mk;
    if (cls == 3'd3 && m_occ[5]) m_close();                          // R4
  endtask

  // driver: offer one instruction and hold it until taken
  task automatic send(input logic [2:0] cls);
    @(negedge clk);
    in_valid = 1'b1;
    in_class = cls;
    in_tag = next_tag;
    m_add(cls, next_tag);
    next_tag = next_tag + 8'd1;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic stop_batch();
    @(negedge clk);
    in_valid = 1'b0;
    in_class = 3'd0;
    m_close();
  endtask

  task automatic drain(input int limit);
    int cnt = 0;
    while (exp_q.size() != 0 && cnt < 3000) begin
      @(negedge clk);
      #3;
      cnt++;
    end
    total++;
    if (exp_q.size() != 0 || (limit > 0 && cnt > limit)) begin
      bad++;
      $display("FAIL %s drain: left=%0d cycles=%0d expected left=0 cycles<=%0d",
               cur_req, exp_q.size(), cnt, limit);
    end
  endtask

  // monitor: compares emitted groups and checks stall hold
  logic [NS+NS*TW-1:0] last_out;
  bit was_stalled = 0;
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      if (was_stalled) begin
        total++;
        if (!grp_valid || {slot_valid, slot_tag} != last_out) begin  // R9 hold
          bad++;
          $display("FAIL R9 hold: got v=%0b %h expected v=1 %h",
                   grp_valid, {slot_valid, slot_tag}, last_out);
        end
      end
      was_stalled = grp_valid && !grp_ready;
      last_out = {slot_valid, slot_tag};
      if (grp_valid && grp_ready) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL %s group: got %h expected none", cur_req, {slot_valid, slot_tag});
        end else begin
          logic [NS+NS*TW-1:0] e;
          e = exp_q.pop_front();
          if (e != {slot_valid, slot_tag}) begin
            bad++;
            $display("FAIL %s group: got %h expected %h", cur_req, {slot_valid, slot_tag}, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    total++;
    if (grp_valid !== 1'b0 || in_ready !== 1'b1) begin               // R1
      bad++;
      $display("FAIL R1 reset: got grp_valid=%b in_ready=%b expected 0 1", grp_valid, in_ready);
    end

    cur_req = "R2";
    repeat (5) send(3'd0);
    stop_batch(); drain(0);

    cur_req = "R3";
    send(3'd3); send(3'd0); send(3'd0);
    stop_batch(); drain(0);

    cur_req = "R4";
    send(3'd0); send(3'd3); send(3'd0); send(3'd3); send(3'd0);
    stop_batch(); drain(0);

    cur_req = "R5";
    send(3'd0); send(3'd1); send(3'd0);
    stop_batch(); drain(0);

    cur_req = "R6";
    send(3'd2); send(3'd3); send(3'd0);
    stop_batch(); drain(0);
    send(3'd3); send(3'd2);
    stop_batch(); drain(0);

    cur_req = "R7";
    send(3'd4); send(3'd0); send(3'd0); send(3'd0); send(3'd5);
    stop_batch(); drain(0);
    send(3'd0); send(3'd5); send(3'd4); send(3'd4);
    stop_batch(); drain(0);

    cur_req = "R8";
    send(3'd0);
    stop_batch(); drain(3);

    cur_req = "R9";
    bp_on = 1;
    for (int i = 0; i < 60; i++) send(3'((i * 7 + i / 3) % 6));
    stop_batch(); drain(0);
    bp_on = 0;

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule